// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block follows the state of a single DMA channel that sources packet data for one USB device endpoint. It keeps a byte down-counter for the current buffer, a channel-enable status, a channel-active status, and three sticky event flags: end of buffer, end of transfer, and descriptor loaded. It presents all of them as one 32-bit status word. The data path, the bus master, the descriptor fetch and the arbitration between channels are outside the block. They appear only as single-cycle strobes and level inputs: a byte moved, a packet done, a grant, the device ending the transfer, a FIFO-empty level and a descriptor-load request.

The enable status comes from a four-state machine. `CH_IDLE` is the disabled state. `CH_RUN` means the channel is enabled and moving data. `CH_LASTPKT` means the device has ended the transfer and the channel is waiting for the last packet to finish. `CH_DRAIN` means software has asked for a disable while a request was in service, and the channel is waiting for the FIFO to empty.

The transitions are as follows:
- IDLE→RUN happens on a software enable write, or on a descriptor load when the load-next bit is held.
- Any enabled state goes back to RUN on a software enable write, which also reloads the count.
- Any enabled state goes to IDLE when the count reaches zero.
- RUN→LASTPKT happens on a device end.
- RUN→IDLE happens on a device end together with packet done, or on a software disable while the channel is not active.
- LASTPKT→IDLE happens on packet done, or on a software disable while the channel is not active.
- RUN→DRAIN and LASTPKT→DRAIN happen on a software disable while the channel is active.
- DRAIN→IDLE happens when the FIFO is empty.

Every input is sampled on the rising clock edge, and the status word changes one cycle after its cause.

Top module: `dma_chan_status`

## Requirements
- R1: A synchronous active-high reset clears every flag and the count. The status word is then 0.
- R2: The status word is laid out as follows:
  - bits 31:16 hold the byte count;
  - bit 6 is descriptor loaded, bit 5 is end of buffer and bit 4 is end of transfer;
  - bit 1 is channel active and bit 0 is channel enable;
  - all other bits read 0.
- R3: A control write with the enable bit at 1 loads the count from `len_in` and sets the enable status. A control write with the enable bit at 1 takes priority over a byte strobe in the same cycle.
- R4: Each byte strobe while enabled lowers the count by one. The count saturates at zero. A byte strobe while disabled has no effect.
- R5: When a byte strobe takes the count from 1 to 0, the end-of-buffer flag sets and the enable status clears.
- R6: After a device end-of-transfer pulse, the enable status stays set until packet done. At packet done the end-of-transfer flag sets and the enable status clears. If both inputs arrive in the same cycle, this happens at once.
- R7: A control write with the enable bit at 0 while the channel is active keeps the enable status set until `fifo_empty` is high, and then clears it. The same write while the channel is not active clears the enable status on the next cycle.
- R8: A grant while enabled sets the active flag, and packet done clears it. The active flag is unaffected by a buffer end, by a descriptor load and by disabling.
- R9: A descriptor load is accepted only while the channel is disabled and the most recent control write had the load-next bit at 1. An accepted load reloads the count from `len_in`, sets the enable status and sets the descriptor-loaded flag. Any other descriptor load is ignored.
- R10: A status read clears the three sticky flags. If a flag's set event arrives in the same cycle as the read, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Software control write strobe |
| ctrl_en | input | 1 | Enable bit value carried by the control write |
| ctrl_ldnxt | input | 1 | Load-next-descriptor bit value carried by the control write |
| len_in | input | CNT_W (16) | Programmed buffer length, used on reload |
| byte_stb | input | 1 | One byte moved |
| dev_eot | input | 1 | Device-initiated end-of-transfer pulse |
| pkt_done | input | 1 | Current packet transfer finished |
| grant | input | 1 | Channel selected as the highest-priority requester |
| fifo_empty | input | 1 | DMA FIFO is empty |
| desc_ld | input | 1 | Descriptor-load request |
| stat_rd | input | 1 | Software status read strobe |
| status | output | CNT_W+16 (32) | Status word |

## Verification
The hardest case to reach is an active flag that outlives a buffer end and carries into the next descriptor. To get there, the stimulus first writes the enable bit with load-next set and a length of two. It grants the channel and sends two byte strobes without a packet done, so the channel falls to idle with the active flag still set. It then requests a descriptor load and checks that enable, active, end of buffer and descriptor loaded all appear together, before a later packet done clears only the active flag. A drain case holds `fifo_empty` low across a disable of an active channel, to show that the enable status outlives the write. A same-cycle byte strobe and status read shows that the set wins over the clear.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_RUN     = 2'd1,
        CH_LASTPKT = 2'd2,
        CH_DRAIN   = 2'd3
    } ch_state_e;

    localparam int FLAG_EOT = 0;
    localparam int FLAG_BUF = 1;
    localparam int FLAG_DSC = 2;
    localparam int NFLAG    = 3;

endpackage

// File: rtl/dma_chan_counter.sv
module dma_chan_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             hit_zero
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - ONE;
        end
    end

    // the strobe that consumes the final byte of the buffer
    assign hit_zero = dec && (cnt == ONE);

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             ctrl_en,
    input  logic             ctrl_ldnxt,
    input  logic             desc_ld,
    input  logic             dev_eot,
    input  logic             pkt_done,
    input  logic             fifo_empty,
    input  logic             hit_zero,
    input  logic             active,
    output ch_state_e        state,
    output logic             load,
    output logic [NFLAG-1:0] set_vec
);

    ch_state_e state_d;
    logic      ldnxt_q;
    logic      go;
    logic      stop;

    assign go   = ctrl_wr && ctrl_en;
    assign stop = ctrl_wr && !ctrl_en;

    // state register and the load-next control bit
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CH_IDLE;
            ldnxt_q <= 1'b0;
        end else begin
            state <= state_d;
            if (ctrl_wr) begin
                ldnxt_q <= ctrl_ldnxt;
            end
        end
    end

    // next state and transition outputs
    always_comb begin
        state_d = state;
        load    = 1'b0;
        set_vec = '0;
        unique case (state)
            CH_IDLE: begin
                if (go) begin
                    state_d = CH_RUN;
                    load    = 1'b1;
                end else if (desc_ld && ldnxt_q) begin
                    state_d           = CH_RUN;
                    load              = 1'b1;
                    set_vec[FLAG_DSC] = 1'b1;
                end
            end
            CH_RUN: begin
                if (go) begin
                    load = 1'b1;
                end else if (hit_zero) begin
                    state_d           = CH_IDLE;
                    set_vec[FLAG_BUF] = 1'b1;
                end else if (dev_eot && pkt_done) begin
                    state_d           = CH_IDLE;
                    set_vec[FLAG_EOT] = 1'b1;
                end else if (dev_eot) begin
                    state_d = CH_LASTPKT;
                end else if (stop) begin
                    state_d = active ? CH_DRAIN : CH_IDLE;
                end
            end
            CH_LASTPKT: begin
                if (go) begin
                    state_d = CH_RUN;
                    load    = 1'b1;
                end else if (hit_zero) begin
                    state_d           = CH_IDLE;
                    set_vec[FLAG_BUF] = 1'b1;
                end else if (pkt_done) begin
                    state_d           = CH_IDLE;
                    set_vec[FLAG_EOT] = 1'b1;
                end else if (stop) begin
                    state_d = active ? CH_DRAIN : CH_IDLE;
                end
            end
            CH_DRAIN: begin
                if (go) begin
                    state_d = CH_RUN;
                    load    = 1'b1;
                end else if (hit_zero) begin
                    state_d           = CH_IDLE;
                    set_vec[FLAG_BUF] = 1'b1;
                end else if (fifo_empty) begin
                    state_d = CH_IDLE;
                end
            end
        endcase
    end

endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set_vec,
    input  logic          clr,
    input  logic          grant,
    input  logic          enable,
    input  logic          pkt_done,
    output logic [NF-1:0] flags,
    output logic          active
);

    // sticky flags: a set in the same cycle as a read survives
    for (genvar gi = 0; gi < NF; gi++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[gi] <= 1'b0;
            end else begin
                flags[gi] <= set_vec[gi] | (flags[gi] & ~clr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (pkt_done) begin
            active <= 1'b0;
        end else if (grant && enable) begin
            active <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
    import dma_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_wr,
    input  logic               ctrl_en,
    input  logic               ctrl_ldnxt,
    input  logic [CNT_W-1:0]   len_in,
    input  logic               byte_stb,
    input  logic               dev_eot,
    input  logic               pkt_done,
    input  logic               grant,
    input  logic               fifo_empty,
    input  logic               desc_ld,
    input  logic               stat_rd,
    output logic [CNT_W+15:0]  status
);

    ch_state_e        state;
    logic             load;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flags;
    logic             active;
    logic             enable;
    logic [CNT_W-1:0] cnt;
    logic             hit_zero;

    assign enable = (state != CH_IDLE);

    dma_chan_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .ctrl_en    (ctrl_en),
        .ctrl_ldnxt (ctrl_ldnxt),
        .desc_ld    (desc_ld),
        .dev_eot    (dev_eot),
        .pkt_done   (pkt_done),
        .fifo_empty (fifo_empty),
        .hit_zero   (hit_zero),
        .active     (active),
        .state      (state),
        .load       (load),
        .set_vec    (set_vec)
    );

    dma_chan_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .len      (len_in),
        .dec      (byte_stb && enable),
        .cnt      (cnt),
        .hit_zero (hit_zero)
    );

    dma_chan_flags #(.NF(NFLAG)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr      (stat_rd),
        .grant    (grant),
        .enable   (enable),
        .pkt_done (pkt_done),
        .flags    (flags),
        .active   (active)
    );

    assign status = {cnt, 9'b0, flags[FLAG_DSC], flags[FLAG_BUF],
                     flags[FLAG_EOT], 2'b0, active, enable};

endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk #(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               ctrl_wr,
    input logic               ctrl_en,
    input logic               byte_stb,
    input logic               dev_eot,
    input logic               pkt_done,
    input logic               fifo_empty,
    input logic               desc_ld,
    input logic               stat_rd,
    input logic [CNT_W+15:0]  status
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (status == '0)); // R1

    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
        (status[15:7] == '0) && (status[3:2] == '0)); // R2

    AST_COUNT_SAT: assert property (@(posedge clk) disable iff (rst)
        (status[CNT_W+15:16] == '0 && !ctrl_wr && !desc_ld)
        |=> (status[CNT_W+15:16] == '0)); // R4

    AST_BUF_END_DISABLES: assert property (@(posedge clk) disable iff (rst)
        $rose(status[5]) |-> (!status[0] && status[CNT_W+15:16] == '0)); // R5

    AST_EOT_DISABLES: assert property (@(posedge clk) disable iff (rst)
        $rose(status[4]) |-> !status[0]); // R6

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (status[0] && status[1] && ctrl_wr && !ctrl_en && !fifo_empty &&
         !byte_stb && !dev_eot && !pkt_done) |=> status[0]); // R7

    AST_ACTIVE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !status[1]); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !byte_stb && !pkt_done && !desc_ld)
        |=> (status[6:4] == 3'b000)); // R10

endmodule

bind dma_chan_status dma_chan_status_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_chan_status_test.sv
module dma_chan_status_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr = 1'b0, ctrl_en = 1'b0, ctrl_ldnxt = 1'b0;
    logic [15:0] len_in = '0;
    logic        byte_stb = 1'b0, dev_eot = 1'b0, pkt_done = 1'b0;
    logic        grant = 1'b0, fifo_empty = 1'b1, desc_ld = 1'b0, stat_rd = 1'b0;
    logic [31:0] status;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    dma_chan_status uut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
        .ctrl_ldnxt(ctrl_ldnxt), .len_in(len_in), .byte_stb(byte_stb),
        .dev_eot(dev_eot), .pkt_done(pkt_done), .grant(grant),
        .fifo_empty(fifo_empty), .desc_ld(desc_ld), .stat_rd(stat_rd),
        .status(status)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        ctrl_wr = 0; byte_stb = 0; dev_eot = 0; pkt_done = 0;
        grant = 0; desc_ld = 0; stat_rd = 0;
    endtask

    task automatic check(input string tag, input logic [31:0] exp);
        nchk++;
        if (status !== exp) begin
            nerr++;
            $display("FAIL %s: status=%h expected %h", tag, status, exp);
        end
    endtask

    task automatic wr_ctrl(input logic en, input logic ld, input logic [15:0] len);
        ctrl_wr = 1; ctrl_en = en; ctrl_ldnxt = ld; len_in = len;
        tick();
    endtask

    task automatic t_reset();
        rst = 1; tick(); tick(); rst = 0;
        check("R1 reset state", 32'h0000_0000);
    endtask

    task automatic t_count_and_buffer_end();
        wr_ctrl(1, 0, 16'd5);
        check("R3 R2 enable loads count", 32'h0005_0001);
        byte_stb = 1; tick(); byte_stb = 1; tick();
        check("R4 decrement", 32'h0003_0001);
        byte_stb = 1; tick(); byte_stb = 1; tick(); byte_stb = 1; tick();
        check("R5 buffer end", 32'h0000_0020);
        byte_stb = 1; tick();
        check("R4 strobe ignored while disabled", 32'h0000_0020);
        stat_rd = 1; tick();
        check("R10 read clears", 32'h0000_0000);
    endtask

    task automatic t_saturate();
        wr_ctrl(1, 0, 16'd0);
        check("R3 zero length enable", 32'h0000_0001);
        byte_stb = 1; tick();
        check("R4 saturates at zero", 32'h0000_0001);
        wr_ctrl(1, 0, 16'd9);
        byte_stb = 1; ctrl_wr = 1; ctrl_en = 1; len_in = 16'd6; tick();
        check("R3 reload beats strobe", 32'h0006_0001);
        wr_ctrl(0, 0, 16'd0);
        check("R7 disable while not active", 32'h0006_0000);
    endtask

    task automatic t_device_end();
        wr_ctrl(1, 0, 16'd10);
        dev_eot = 1; tick();
        check("R6 enable held after device end", 32'h000A_0001);
        byte_stb = 1; tick();
        check("R4 strobe in last packet", 32'h0009_0001);
        pkt_done = 1; tick();
        check("R6 end of transfer", 32'h0009_0010);
        stat_rd = 1; tick();
        check("R10 read clears end of transfer", 32'h0009_0000);
        wr_ctrl(1, 0, 16'd3);
        dev_eot = 1; pkt_done = 1; tick();
        check("R6 same-cycle end", 32'h0003_0010);
        stat_rd = 1; tick();
    endtask

    task automatic t_drain();
        wr_ctrl(1, 0, 16'd8);
        grant = 1; tick();
        check("R8 grant sets active", 32'h0008_0003);
        fifo_empty = 0;
        wr_ctrl(0, 0, 16'd0);
        check("R7 enable held while draining", 32'h0008_0003);
        tick();
        check("R7 still draining", 32'h0008_0003);
        fifo_empty = 1; tick();
        check("R7 drained", 32'h0008_0002);
        pkt_done = 1; tick();
        check("R8 packet done clears active", 32'h0008_0000);
    endtask

    task automatic t_active_reload();
        wr_ctrl(1, 1, 16'd2);
        grant = 1; tick();
        byte_stb = 1; tick(); byte_stb = 1; tick();
        check("R8 active survives buffer end", 32'h0000_0022);
        desc_ld = 1; len_in = 16'd4; tick();
        check("R9 descriptor load", 32'h0004_0063);
        pkt_done = 1; tick();
        check("R8 active clears on packet done", 32'h0004_0061);
        stat_rd = 1; tick();
        check("R10 read clears all flags", 32'h0004_0001);
    endtask

    task automatic t_desc_gate();
        wr_ctrl(0, 0, 16'd0);
        desc_ld = 1; len_in = 16'd7; tick();
        check("R9 load ignored without load-next", 32'h0004_0000);
        wr_ctrl(1, 1, 16'd5);
        desc_ld = 1; len_in = 16'd9; tick();
        check("R9 load ignored while enabled", 32'h0005_0001);
        wr_ctrl(0, 1, 16'd0);
    endtask

    task automatic t_set_wins();
        wr_ctrl(1, 0, 16'd1);
        byte_stb = 1; stat_rd = 1; tick();
        check("R10 set wins over read", 32'h0000_0020);
        stat_rd = 1; tick();
        check("R10 later read clears", 32'h0000_0000);
    endtask

    initial begin
        #(4 * 200000);
        nerr++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_count_and_buffer_end();
        t_saturate();
        t_device_end();
        t_drain();
        t_active_reload();
        t_desc_gate();
        t_set_wins();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule